// File: doc/BRIEF.md
# Reset Source and Boot-Bank Controller

This block gathers every restart cause of a small processor (power-on, external pin, watchdog timeout, software request and a supply-low comparator) and turns them into one stretched core reset. It also keeps the two bank-control bits, SWR (software-reset marker) and BSEL (bank select), and maps each fetch address onto either the boot code or user code block 0. The supply-low flag is filtered first. A qualified brownout then either raises an interrupt or resets the core, depending on a software enable bit.

Each restart cause changes the bank bits in its own way, so after a restart the processor fetches from the bank that suits the cause. Software may write BSEL directly when no reset source is active. The power-on input doubles as the block's synchronous reset.

Top module: `rst_boot_ctrl`

## Requirements
- R1: `bo_qual` rises only after `vlow_i` has been sampled high on 4 consecutive clock edges; a dip of 3 or fewer cycles causes neither interrupt nor reset.
- R2: With `bo_ie_i`=1, a qualified brownout drives `bo_irq_o`=1 and `bo_vec_o`=16'h004B and does not assert `core_rst_o`; `bo_vec_o` is 0 when there is no interrupt.
- R3: With `bo_ie_i`=0, a qualified brownout is a reset source; clearing `bo_ie_i` while the brownout is still qualified asserts `core_rst_o` on the next cycle.
- R4: Power-on (`por_i`) and external reset (`ext_rst_i`) force `swr_o`=0 and `bsel_o`=0.
- R5: Watchdog and brownout resets force `bsel_o`=0 and leave `swr_o` unchanged.
- R6: A software reset (`swr_req_i`) sets `swr_o`=1 and clears `bsel_o`.
- R7: When several sources are active in one cycle, only the highest one updates the bits, in the order power-on, external, watchdog, brownout, software.
- R8: `boot_sel_o`=1 (boot code) only when `fetch_addr_i` < 16'h2000 and `swr_o`=0 and `bsel_o`=0; otherwise `boot_sel_o`=0 (user code block 0). With `bsel_o`=1, the low 8 kB maps to user code whatever `swr_o` holds.
- R9: `core_rst_o` goes high on the cycle after any reset source is sampled and stays high for exactly 16 cycles after the last edge that sampled an active source.
- R10: With no reset source active, `bsel_we_i`=1 loads `bsel_d_i` into `bsel_o` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on reset; also the block's synchronous reset |
| ext_rst_i | input | 1 | External reset pin, active high |
| wdt_i | input | 1 | Watchdog timeout |
| swr_req_i | input | 1 | Software reset request |
| vlow_i | input | 1 | Supply-below-threshold comparator flag |
| bo_ie_i | input | 1 | Brownout interrupt enable |
| bsel_we_i | input | 1 | Software write strobe for BSEL |
| bsel_d_i | input | 1 | Value written to BSEL |
| fetch_addr_i | input | 16 | Program fetch address |
| core_rst_o | output | 1 | Stretched core reset |
| bo_irq_o | output | 1 | Brownout interrupt request |
| bo_vec_o | output | 16 | Brownout interrupt vector |
| swr_o | output | 1 | SWR status bit |
| bsel_o | output | 1 | BSEL status bit |
| boot_sel_o | output | 1 | 1 = boot code, 0 = user code block 0 |

## Verification
On every cycle the assertions check the per-source bit updates (external clears both bits, watchdog keeps SWR, software sets it, any source clears BSEL), how the brownout qualifier rises and drops against the comparator input, and that the core reset rises after a source and never falls straight after one. Only the bench scenarios show the exact 4-cycle filter boundary, the interrupt/reset choice made by the enable bit, the full priority order over every mix of simultaneous sources from every starting bit state, the exact 16-cycle stretch length, and the address-to-bank map over a sweep of the 64 kB space.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

    localparam int          ADDR_W    = 16;
    localparam int          BOOT_AW   = 13;
    localparam int          FILT_N    = 4;
    localparam int          STRETCH_N = 16;
    localparam logic [15:0] BO_VEC    = 16'h004B;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_EXT,
        SRC_WDT,
        SRC_BOR,
        SRC_SW
    } rst_src_e;

    typedef struct packed {
        logic swr;
        logic bsel;
    } bank_bits_t;

    // Priority pick among the non-power-on sources.
    function automatic rst_src_e pick_src(logic ext, logic wdt, logic bor, logic sw);
        if (ext)      return SRC_EXT;
        else if (wdt) return SRC_WDT;
        else if (bor) return SRC_BOR;
        else if (sw)  return SRC_SW;
        else          return SRC_NONE;
    endfunction

    function automatic bank_bits_t apply_src(rst_src_e s, bank_bits_t cur);
        bank_bits_t nxt;
        nxt = cur;
        case (s)
            SRC_EXT:          nxt = '{swr: 1'b0, bsel: 1'b0};
            SRC_WDT, SRC_BOR: nxt.bsel = 1'b0;
            SRC_SW:           nxt = '{swr: 1'b1, bsel: 1'b0};
            default:          nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/bod_filter.sv
module bod_filter #(
    parameter int FILT_N = rbc_pkg::FILT_N
) (
    input  logic clk,
    input  logic rst,
    input  logic vlow_i,
    output logic qual_o
);
    localparam int CW = $clog2(FILT_N + 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            run_cnt <= '0;
        else if (!vlow_i)
            run_cnt <= '0;
        else if (run_cnt != CW'(FILT_N))
            run_cnt <= run_cnt + 1'b1;
    end

    assign qual_o = (run_cnt == CW'(FILT_N));

    // R1: the qualifier only rises while the flag is still low-supply
    p_rise_needs_vlow_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(qual_o) |-> $past(vlow_i));
    // R1: a healthy supply sample drops the qualifier
    p_drop_on_good_r1: assert property (@(posedge clk) disable iff (rst)
        !vlow_i |=> !qual_o);

endmodule

// File: rtl/rst_seq.sv
module rst_seq
    import rbc_pkg::*;
#(
    parameter int STRETCH_N = rbc_pkg::STRETCH_N
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_i,
    input  logic       wdt_i,
    input  logic       bor_i,
    input  logic       sw_i,
    input  logic       bsel_we_i,
    input  logic       bsel_d_i,
    output bank_bits_t bits_o,
    output logic       core_rst_o
);
    localparam int SW_CNT = $clog2(STRETCH_N + 1);

    rst_src_e          src;
    logic              any_src;
    bank_bits_t        bits_q;
    logic [SW_CNT-1:0] hold_cnt;

    always_comb begin
        src     = pick_src(ext_i, wdt_i, bor_i, sw_i);
        any_src = (src != SRC_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst)
            bits_q <= '{swr: 1'b0, bsel: 1'b0};
        else if (any_src)
            bits_q <= apply_src(src, bits_q);
        else if (bsel_we_i)
            bits_q.bsel <= bsel_d_i;
    end

    always_ff @(posedge clk) begin
        if (rst || any_src)
            hold_cnt <= SW_CNT'(STRETCH_N);
        else if (hold_cnt != '0)
            hold_cnt <= hold_cnt - 1'b1;
    end

    assign bits_o     = bits_q;
    assign core_rst_o = (hold_cnt != '0);

    p_ext_clears_r4: assert property (@(posedge clk) disable iff (rst)
        ext_i |=> (!bits_o.swr && !bits_o.bsel));
    p_src_clears_bsel_r5: assert property (@(posedge clk) disable iff (rst)
        (ext_i || wdt_i || bor_i || sw_i) |=> !bits_o.bsel);
    p_wdt_keeps_swr_r5: assert property (@(posedge clk) disable iff (rst)
        (wdt_i && !ext_i) |=> (bits_o.swr == $past(bits_o.swr)));
    p_sw_sets_swr_r6: assert property (@(posedge clk) disable iff (rst)
        (sw_i && !ext_i && !wdt_i && !bor_i) |=> bits_o.swr);
    p_rst_follows_src_r9: assert property (@(posedge clk) disable iff (rst)
        (ext_i || wdt_i || bor_i || sw_i) |=> core_rst_o);
    p_no_early_release_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst_o) |-> !$past(ext_i || wdt_i || bor_i || sw_i));

endmodule

// File: rtl/bank_map.sv
module bank_map
    import rbc_pkg::*;
#(
    parameter int ADDR_W  = rbc_pkg::ADDR_W,
    parameter int BOOT_AW = rbc_pkg::BOOT_AW
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  bank_bits_t        bits_i,
    output logic              boot_sel_o
);
    localparam int HI_W = ADDR_W - BOOT_AW;

    logic low_window;

    assign low_window = (addr_i[ADDR_W-1:BOOT_AW] == HI_W'(0));
    assign boot_sel_o = low_window && !bits_i.swr && !bits_i.bsel;

endmodule

// File: rtl/rst_boot_ctrl.sv
module rst_boot_ctrl
    import rbc_pkg::*;
#(
    parameter int ADDR_W    = rbc_pkg::ADDR_W,
    parameter int BOOT_AW   = rbc_pkg::BOOT_AW,
    parameter int FILT_N    = rbc_pkg::FILT_N,
    parameter int STRETCH_N = rbc_pkg::STRETCH_N
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              ext_rst_i,
    input  logic              wdt_i,
    input  logic              swr_req_i,
    input  logic              vlow_i,
    input  logic              bo_ie_i,
    input  logic              bsel_we_i,
    input  logic              bsel_d_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    output logic              core_rst_o,
    output logic              bo_irq_o,
    output logic [15:0]       bo_vec_o,
    output logic              swr_o,
    output logic              bsel_o,
    output logic              boot_sel_o
);
    logic       bo_qual;
    logic       bor_src;
    bank_bits_t bits;

    bod_filter #(.FILT_N(FILT_N)) u_filt (
        .clk    (clk),
        .rst    (por_i),
        .vlow_i (vlow_i),
        .qual_o (bo_qual)
    );

    assign bor_src  = bo_qual && !bo_ie_i;
    assign bo_irq_o = bo_qual && bo_ie_i;
    assign bo_vec_o = bo_irq_o ? BO_VEC : 16'h0000;

    rst_seq #(.STRETCH_N(STRETCH_N)) u_seq (
        .clk        (clk),
        .rst        (por_i),
        .ext_i      (ext_rst_i),
        .wdt_i      (wdt_i),
        .bor_i      (bor_src),
        .sw_i       (swr_req_i),
        .bsel_we_i  (bsel_we_i),
        .bsel_d_i   (bsel_d_i),
        .bits_o     (bits),
        .core_rst_o (core_rst_o)
    );

    bank_map #(.ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW)) u_map (
        .addr_i     (fetch_addr_i),
        .bits_i     (bits),
        .boot_sel_o (boot_sel_o)
    );

    assign swr_o  = bits.swr;
    assign bsel_o = bits.bsel;

    // R3: a brownout with the enable clear leads to a core reset
    p_bor_resets_r3: assert property (@(posedge clk) disable iff (por_i)
        (bo_qual && !bo_ie_i) |=> core_rst_o);

endmodule

// File: tb/sim_rst_boot_ctrl.sv
module sim_rst_boot_ctrl;

    logic        clk = 1'b0;
    logic        por_i = 1'b1, ext_rst_i = 1'b0, wdt_i = 1'b0, swr_req_i = 1'b0;
    logic        vlow_i = 1'b0, bo_ie_i = 1'b0, bsel_we_i = 1'b0, bsel_d_i = 1'b0;
    logic [15:0] fetch_addr_i = '0;
    logic        core_rst_o, bo_irq_o, swr_o, bsel_o, boot_sel_o;
    logic [15:0] bo_vec_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rst_boot_ctrl u0 (
        .clk(clk), .por_i(por_i), .ext_rst_i(ext_rst_i), .wdt_i(wdt_i),
        .swr_req_i(swr_req_i), .vlow_i(vlow_i), .bo_ie_i(bo_ie_i),
        .bsel_we_i(bsel_we_i), .bsel_d_i(bsel_d_i), .fetch_addr_i(fetch_addr_i),
        .core_rst_o(core_rst_o), .bo_irq_o(bo_irq_o), .bo_vec_o(bo_vec_o),
        .swr_o(swr_o), .bsel_o(bsel_o), .boot_sel_o(boot_sel_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic settle();
        for (int i = 0; i < 18; i++) tick();
    endtask

    // one-cycle source pulse; returns at the negedge after the sampling edge
    task automatic pulse(input bit e, input bit w, input bit s);
        ext_rst_i = e; wdt_i = w; swr_req_i = s;
        tick();
        ext_rst_i = 0; wdt_i = 0; swr_req_i = 0;
    endtask

    task automatic set_state(input bit sw, input bit bs);
        if (sw) pulse(0, 0, 1); else pulse(1, 0, 0);
        settle();
        if (bs) begin
            bsel_we_i = 1; bsel_d_i = 1;
            tick();
            bsel_we_i = 0; bsel_d_i = 0;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        // R4: power-on state
        chk("R4 por swr", swr_o, 0);
        chk("R4 por bsel", bsel_o, 0);
        chk("R9 core_rst in por", core_rst_o, 1);
        chk("R2 no irq in reset", bo_irq_o, 0);
        por_i = 0;
        settle();
        chk("R9 released after por", core_rst_o, 0);

        // R10: BSEL write with no source
        bsel_we_i = 1; bsel_d_i = 1; tick(); bsel_we_i = 0; bsel_d_i = 0;
        chk("R10 bsel write 1", bsel_o, 1);
        chk("R10 no reset from write", core_rst_o, 0);
        bsel_we_i = 1; bsel_d_i = 0; tick(); bsel_we_i = 0;
        chk("R10 bsel write 0", bsel_o, 0);

        // R9: exact stretch length after a single-cycle source
        pulse(1, 0, 0);
        chk("R9 stretch cycle 1", core_rst_o, 1);
        for (int i = 2; i <= 16; i++) begin
            tick();
            chk("R9 stretch hold", core_rst_o, 1);
        end
        tick();
        chk("R9 stretch end", core_rst_o, 0);

        // R4 R5 R6 R7: every mix of ext/wdt/sw from every bit state
        for (int st = 0; st < 4; st++) begin
            for (int mix = 1; mix < 8; mix++) begin
                bit e, w, s, sw0, bs0, exp_swr;
                sw0 = st[1]; bs0 = st[0];
                e = mix[2]; w = mix[1]; s = mix[0];
                set_state(sw0, bs0);
                chk("R10 setup swr", swr_o, sw0);
                chk("R10 setup bsel", bsel_o, bs0);
                if (e)      exp_swr = 0;
                else if (w) exp_swr = sw0;
                else        exp_swr = 1;
                pulse(e, w, s);
                chk("R7 priority swr", swr_o, exp_swr);
                chk("R5 R6 bsel cleared", bsel_o, 0);
                chk("R9 core_rst", core_rst_o, 1);
                settle();
            end
        end

        // R8: address sweep for all four bit states
        for (int st = 0; st < 4; st++) begin
            set_state(st[1], st[0]);
            for (int a = 0; a < 65536; a += 256) begin
                fetch_addr_i = 16'(a + (a % 251));
                #1;
                chk("R8 bank select", boot_sel_o,
                    ((fetch_addr_i < 16'h2000) && !st[1] && !st[0]) ? 1 : 0);
            end
        end
        fetch_addr_i = '0;
        settle();

        // R1: dips of 1..3 cycles ignored
        bo_ie_i = 1;
        for (int d = 1; d <= 3; d++) begin
            vlow_i = 1;
            for (int i = 0; i < d; i++) begin
                tick();
                chk("R1 short dip no irq", bo_irq_o, 0);
            end
            vlow_i = 0;
            tick(); tick();
            chk("R1 short dip no irq after", bo_irq_o, 0);
            chk("R1 short dip no reset", core_rst_o, 0);
        end

        // R1 R2: held low -> interrupt after 4th edge
        set_state(1, 1);
        vlow_i = 1;
        tick(); tick(); tick();
        chk("R1 not yet at 3", bo_irq_o, 0);
        tick();
        chk("R2 irq at 4", bo_irq_o, 1);
        chk("R2 vector", bo_vec_o, 16'h004B);
        tick(); tick();
        chk("R2 no reset with ie", core_rst_o, 0);
        chk("R2 bits kept", {swr_o, bsel_o}, 2'b11);

        // R3: clearing enable while qualified -> reset; R5 brownout keeps swr
        bo_ie_i = 0;
        #1;
        chk("R2 vec zero without irq", bo_vec_o, 0);
        tick();
        chk("R3 reset after ie clear", core_rst_o, 1);
        chk("R5 bor keeps swr", swr_o, 1);
        chk("R5 bor clears bsel", bsel_o, 0);
        vlow_i = 0;
        settle();
        chk("R3 released", core_rst_o, 0);

        // R3: enable clear from start -> reset on 5th edge
        vlow_i = 1;
        tick(); tick(); tick(); tick();
        chk("R3 no reset before qualify", core_rst_o, 0);
        tick();
        chk("R3 bor reset", core_rst_o, 1);
        chk("R2 no irq when disabled", bo_irq_o, 0);
        vlow_i = 0;
        settle();

        // R7: external beats an active brownout
        set_state(1, 0);
        vlow_i = 1;
        for (int i = 0; i < 4; i++) tick();
        ext_rst_i = 1; tick(); ext_rst_i = 0;
        chk("R7 ext over bor swr", swr_o, 0);
        vlow_i = 0;
        settle();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule